// File: doc/BRIEF.md
# Multiplexed Bus Latch Exchanger

This block joins one 12-bit host port to two 12-bit bank ports through four independent storage latches. Two latches carry host data down to bank 1 and bank 2. The other two carry bank data back up toward the host. Because the two downward latches have separate enables, one host bus can be split across an even and an odd bank. A select input then merges the two upward paths back onto the host port. Each port has its own active-low enable that decides whether the port drives.

Each bidirectional port is split into an input vector, an input-driven flag, an output vector and an output-enable vector, so the whole block stays synthesizable. A latch is modelled on the clock: it passes its input through in the same cycle while its enable is high, and keeps the last captured value once the enable is low. Every port input has a bus-hold register. When the input is not driven, this register supplies the last level that was driven on it.

Top module: `bus_latch_exchanger`

## Requirements
- R1: While `rstN` is low, all four latches and all three bus-hold registers are cleared to zero, independent of the clock. With no latch open, every data output then reads zero.
- R2: While `leHostToBank1` (or `leHostToBank2`) is high, `bank1Out` (or `bank2Out`) equals the effective host input in the same cycle.
- R3: While a downward enable is low, the matching bank output keeps the effective host input captured at the last rising clock edge at which that enable was high. Host input changes made meanwhile have no effect on it.
- R4: While `leBank1ToHost` (or `leBank2ToHost`) is high, the matching upward latch passes the effective bank input through in the same cycle. While the enable is low, the latch keeps the value captured at the last rising edge at which the enable was high.
- R5: `hostOut` shows the bank-1 upward latch when `selBank1` is 1, and the bank-2 upward latch when `selBank1` is 0.
- R6: An active-low enable that is 0 sets every bit of that port's output-enable vector to 1. An enable that is 1 sets every bit to 0. The data output keeps showing the latch value either way.
- R7: Using the two downward enables, new host data can be steered to bank 1 only, to bank 2 only, or to both at once.
- R8: When a port's drive flag is 0, the effective input of that port is the value present at the last rising edge at which the flag was 1, or zero if there was none since reset. A value on an undriven input is ignored.
- R9: Opening or closing one latch never changes the value stored in any other latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the latches and the bus-hold registers |
| rstN | input | 1 | Asynchronous active-low clear |
| hostIn | input | 12 | Value present on the host port |
| hostInDrv | input | 1 | 1 when the host port is driven from outside |
| hostOut | output | 12 | Value the block offers to the host port |
| hostOutEn | output | 12 | Per-bit drive enable for the host port |
| bank1In | input | 12 | Value present on bank port 1 |
| bank1InDrv | input | 1 | 1 when bank port 1 is driven from outside |
| bank1Out | output | 12 | Value the block offers to bank port 1 |
| bank1OutEn | output | 12 | Per-bit drive enable for bank port 1 |
| bank2In | input | 12 | Value present on bank port 2 |
| bank2InDrv | input | 1 | 1 when bank port 2 is driven from outside |
| bank2Out | output | 12 | Value the block offers to bank port 2 |
| bank2OutEn | output | 12 | Per-bit drive enable for bank port 2 |
| leHostToBank1 | input | 1 | Enable of the host-to-bank-1 latch |
| leHostToBank2 | input | 1 | Enable of the host-to-bank-2 latch |
| leBank1ToHost | input | 1 | Enable of the bank-1-to-host latch |
| leBank2ToHost | input | 1 | Enable of the bank-2-to-host latch |
| selBank1 | input | 1 | 1 routes the bank-1 upward latch to the host, 0 routes bank 2 |
| oeHostN | input | 1 | Active-low drive enable for the host port |
| oeBank1N | input | 1 | Active-low drive enable for bank port 1 |
| oeBank2N | input | 1 | Active-low drive enable for bank port 2 |

## Verification
Transparent paths, output enables and the select mux all respond in the same cycle as their stimulus. The bench therefore applies inputs on the falling edge and samples one nanosecond later, before the next rising edge. Held values and bus-hold values depend on what was present at the previous rising edge. The bench's expected model updates its stored copies only after that edge, so each check compares against the state one edge old. Checks on a port that is driven from outside while its own enable is active are counted as contention and skipped.

// File: rtl/ble_pkg.sv
package ble_pkg;
  localparam int NBANK = 2;

  typedef struct packed {
    logic [NBANK-1:0] passDown;   // host -> bank latch open
    logic [NBANK-1:0] passUp;     // bank -> host latch open
    logic             upFromB1;   // host mux picks bank 1
    logic             driveHost;  // host port drives
    logic [NBANK-1:0] driveBank;  // bank ports drive
  } ctrlStrobesT;
endpackage

// File: rtl/ble_ctrl.sv
module ble_ctrl
  import ble_pkg::*;
(
  input  logic        leHostToBank1,
  input  logic        leHostToBank2,
  input  logic        leBank1ToHost,
  input  logic        leBank2ToHost,
  input  logic        selBank1,
  input  logic        oeHostN,
  input  logic        oeBank1N,
  input  logic        oeBank2N,
  output ctrlStrobesT strobes
);
  always_comb begin
    strobes.passDown  = {leHostToBank2, leHostToBank1};
    strobes.passUp    = {leBank2ToHost, leBank1ToHost};
    strobes.upFromB1  = selBank1;
    strobes.driveHost = ~oeHostN;
    strobes.driveBank = {~oeBank2N, ~oeBank1N};
  end
endmodule

// File: rtl/ble_bushold.sv
module ble_bushold #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] dIn,
  input  logic         drv,
  output logic [W-1:0] dEff
);
  logic [W-1:0] holdReg;
  logic         live;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
      live    <= 1'b0;
    end else begin
      live <= 1'b1;
      if (drv) holdReg <= dIn;
    end
  end

  assign dEff = drv ? dIn : holdReg;

  // R8
  bushold_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (live && !drv) |-> (dEff == $past(dEff)));
endmodule

// File: rtl/ble_latch.sv
module ble_latch #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stored;
  logic         live;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stored <= '0;
      live   <= 1'b0;
    end else begin
      live <= 1'b1;
      if (le) stored <= d;
    end
  end

  assign q = le ? d : stored;

  // R3
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (live && !le && !$past(le)) |-> $stable(q));
endmodule

// File: rtl/ble_datapath.sv
module ble_datapath
  import ble_pkg::*;
#(
  parameter int W = 12
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobesT                strobes,
  input  logic [W-1:0]               hostIn,
  input  logic                       hostInDrv,
  input  logic [NBANK-1:0][W-1:0]    bankIn,
  input  logic [NBANK-1:0]           bankInDrv,
  output logic [W-1:0]               hostOut,
  output logic [W-1:0]               hostOutEn,
  output logic [NBANK-1:0][W-1:0]    bankOut,
  output logic [NBANK-1:0][W-1:0]    bankOutEn
);
  logic [W-1:0]            hostEff;
  logic [NBANK-1:0][W-1:0] bankEff;
  logic [NBANK-1:0][W-1:0] upQ;

  ble_bushold #(.W(W)) uHostHold (
    .clk(clk), .rstN(rstN), .dIn(hostIn), .drv(hostInDrv), .dEff(hostEff)
  );

  for (genvar b = 0; b < NBANK; b++) begin : gBank
    ble_bushold #(.W(W)) uBankHold (
      .clk(clk), .rstN(rstN), .dIn(bankIn[b]), .drv(bankInDrv[b]),
      .dEff(bankEff[b])
    );
    ble_latch #(.W(W)) uDown (
      .clk(clk), .rstN(rstN), .le(strobes.passDown[b]), .d(hostEff),
      .q(bankOut[b])
    );
    ble_latch #(.W(W)) uUp (
      .clk(clk), .rstN(rstN), .le(strobes.passUp[b]), .d(bankEff[b]),
      .q(upQ[b])
    );
    assign bankOutEn[b] = {W{strobes.driveBank[b]}};

    // R2
    down_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobes.passDown[b] |-> (bankOut[b] == hostEff));
    // R4
    up_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobes.passUp[b] |-> (upQ[b] == bankEff[b]));
  end

  assign hostOut   = strobes.upFromB1 ? upQ[0] : upQ[1];
  assign hostOutEn = {W{strobes.driveHost}};

  // R5
  sel_b1_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.upFromB1 && strobes.passUp[0]) |-> (hostOut == bankEff[0]));
  // R5
  sel_b2_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.upFromB1 && strobes.passUp[1]) |-> (hostOut == bankEff[1]));
endmodule

// File: rtl/bus_latch_exchanger.sv
module bus_latch_exchanger
  import ble_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] hostIn,
  input  logic         hostInDrv,
  output logic [W-1:0] hostOut,
  output logic [W-1:0] hostOutEn,
  input  logic [W-1:0] bank1In,
  input  logic         bank1InDrv,
  output logic [W-1:0] bank1Out,
  output logic [W-1:0] bank1OutEn,
  input  logic [W-1:0] bank2In,
  input  logic         bank2InDrv,
  output logic [W-1:0] bank2Out,
  output logic [W-1:0] bank2OutEn,
  input  logic         leHostToBank1,
  input  logic         leHostToBank2,
  input  logic         leBank1ToHost,
  input  logic         leBank2ToHost,
  input  logic         selBank1,
  input  logic         oeHostN,
  input  logic         oeBank1N,
  input  logic         oeBank2N
);
  ctrlStrobesT             strobes;
  logic [NBANK-1:0][W-1:0] bankInV;
  logic [NBANK-1:0][W-1:0] bankOutV;
  logic [NBANK-1:0][W-1:0] bankOutEnV;

  ble_ctrl uCtrl (
    .leHostToBank1(leHostToBank1), .leHostToBank2(leHostToBank2),
    .leBank1ToHost(leBank1ToHost), .leBank2ToHost(leBank2ToHost),
    .selBank1(selBank1), .oeHostN(oeHostN), .oeBank1N(oeBank1N),
    .oeBank2N(oeBank2N), .strobes(strobes)
  );

  assign bankInV = {bank2In, bank1In};

  ble_datapath #(.W(W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .hostIn(hostIn), .hostInDrv(hostInDrv),
    .bankIn(bankInV), .bankInDrv({bank2InDrv, bank1InDrv}),
    .hostOut(hostOut), .hostOutEn(hostOutEn),
    .bankOut(bankOutV), .bankOutEn(bankOutEnV)
  );

  assign bank1Out   = bankOutV[0];
  assign bank2Out   = bankOutV[1];
  assign bank1OutEn = bankOutEnV[0];
  assign bank2OutEn = bankOutEnV[1];

  // R6
  host_oe_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    !oeHostN |-> (hostOutEn == {W{1'b1}}));
  // R6
  bank1_oe_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    oeBank1N |-> (bank1OutEn == '0));
  // R6
  bank2_oe_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    oeBank2N |-> (bank2OutEn == '0));
endmodule

// File: tb/bus_latch_exchanger_bench.sv
module bus_latch_exchanger_bench;
  localparam int W = 12;
  localparam int NROW = 12;

  typedef struct packed {
    logic [W-1:0] hIn;  logic hD;
    logic [W-1:0] b1In; logic b1D;
    logic [W-1:0] b2In; logic b2D;
    logic [3:0]   le;   // {up2, up1, down2, down1}
    logic         sel;
    logic [2:0]   oeN;  // {bank2, bank1, host}
  } rowT;

  localparam rowT TBL [NROW] = '{
    '{12'h0A1, 1'b1, 12'h000, 1'b0, 12'h000, 1'b0, 4'b0011, 1'b1, 3'b001},
    '{12'h0B2, 1'b1, 12'h000, 1'b0, 12'h000, 1'b0, 4'b0001, 1'b1, 3'b001},
    '{12'h0C3, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 4'b0011, 1'b1, 3'b001},
    '{12'h0D4, 1'b1, 12'h000, 1'b0, 12'h000, 1'b0, 4'b0000, 1'b1, 3'b001},
    '{12'h000, 1'b0, 12'h5A5, 1'b1, 12'h3C3, 1'b1, 4'b1100, 1'b1, 3'b110},
    '{12'h000, 1'b0, 12'h5A5, 1'b1, 12'h3C3, 1'b1, 4'b1100, 1'b0, 3'b110},
    '{12'h000, 1'b0, 12'h777, 1'b1, 12'h888, 1'b1, 4'b0100, 1'b0, 3'b110},
    '{12'h000, 1'b0, 12'h777, 1'b1, 12'h888, 1'b1, 4'b0100, 1'b1, 3'b110},
    '{12'h000, 1'b0, 12'hFFF, 1'b1, 12'h999, 1'b1, 4'b0000, 1'b1, 3'b110},
    '{12'h000, 1'b0, 12'h123, 1'b0, 12'h999, 1'b1, 4'b0100, 1'b1, 3'b110},
    '{12'h456, 1'b1, 12'h000, 1'b0, 12'h000, 1'b0, 4'b0010, 1'b0, 3'b111},
    '{12'hABC, 1'b0, 12'hDEF, 1'b0, 12'h321, 1'b0, 4'b0000, 1'b0, 3'b000}
  };

  logic clk = 1'b0;
  logic rstN;
  logic [W-1:0] hostIn, bank1In, bank2In;
  logic hostInDrv, bank1InDrv, bank2InDrv;
  logic [W-1:0] hostOut, hostOutEn, bank1Out, bank1OutEn, bank2Out, bank2OutEn;
  logic [3:0] leV;
  logic selBank1;
  logic [2:0] oeV;

  int checks = 0;
  int failures = 0;
  int contentions = 0;
  bit finished = 0;

  // expected-state model built from the requirements
  logic [W-1:0] mH, mB1, mB2, mD1, mD2, mU1, mU2;

  always #2 clk = ~clk;

  bus_latch_exchanger #(.W(W)) u_bus_latch_exchanger (
    .clk(clk), .rstN(rstN),
    .hostIn(hostIn), .hostInDrv(hostInDrv), .hostOut(hostOut), .hostOutEn(hostOutEn),
    .bank1In(bank1In), .bank1InDrv(bank1InDrv), .bank1Out(bank1Out), .bank1OutEn(bank1OutEn),
    .bank2In(bank2In), .bank2InDrv(bank2InDrv), .bank2Out(bank2Out), .bank2OutEn(bank2OutEn),
    .leHostToBank1(leV[0]), .leHostToBank2(leV[1]),
    .leBank1ToHost(leV[2]), .leBank2ToHost(leV[3]),
    .selBank1(selBank1), .oeHostN(oeV[0]), .oeBank1N(oeV[1]), .oeBank2N(oeV[2])
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearModel();
    mH = '0; mB1 = '0; mB2 = '0; mD1 = '0; mD2 = '0; mU1 = '0; mU2 = '0;
  endtask

  task automatic applyRow(input rowT r);
    hostIn = r.hIn; hostInDrv = r.hD;
    bank1In = r.b1In; bank1InDrv = r.b1D;
    bank2In = r.b2In; bank2InDrv = r.b2D;
    leV = r.le; selBank1 = r.sel; oeV = r.oeN;
  endtask

  // called at falling edge with inputs applied; checks then advances one edge
  task automatic checkAndStep();
    logic [W-1:0] hE, b1E, b2E, d1, d2, u1, u2, expHost;
    #1;
    hE  = hostInDrv  ? hostIn  : mH;
    b1E = bank1InDrv ? bank1In : mB1;
    b2E = bank2InDrv ? bank2In : mB2;
    d1 = leV[0] ? hE  : mD1;
    d2 = leV[1] ? hE  : mD2;
    u1 = leV[2] ? b1E : mU1;
    u2 = leV[3] ? b2E : mU2;
    expHost = selBank1 ? u1 : u2;
    if (hostInDrv && !oeV[0]) begin
      contentions++;
      $display("NOTE contention on host port, data not checked");
    end else
      check(hostOut == expHost, "R4 R5 host data", hostOut, expHost);
    if (bank1InDrv && !oeV[1]) begin
      contentions++;
      $display("NOTE contention on bank1 port, data not checked");
    end else
      check(bank1Out == d1, "R2 R3 R7 R8 R9 bank1 data", bank1Out, d1);
    if (bank2InDrv && !oeV[2]) begin
      contentions++;
      $display("NOTE contention on bank2 port, data not checked");
    end else
      check(bank2Out == d2, "R2 R3 R7 R8 R9 bank2 data", bank2Out, d2);
    check(hostOutEn  == (oeV[0] ? '0 : {W{1'b1}}), "R6 host enable",
          hostOutEn, oeV[0] ? '0 : {W{1'b1}});
    check(bank1OutEn == (oeV[1] ? '0 : {W{1'b1}}), "R6 bank1 enable",
          bank1OutEn, oeV[1] ? '0 : {W{1'b1}});
    check(bank2OutEn == (oeV[2] ? '0 : {W{1'b1}}), "R6 bank2 enable",
          bank2OutEn, oeV[2] ? '0 : {W{1'b1}});
    @(posedge clk);
    if (hostInDrv)  mH  = hostIn;
    if (bank1InDrv) mB1 = bank1In;
    if (bank2InDrv) mB2 = bank2In;
    if (leV[0]) mD1 = hE;
    if (leV[1]) mD2 = hE;
    if (leV[2]) mU1 = b1E;
    if (leV[3]) mU2 = b2E;
    @(negedge clk);
  endtask

  task automatic checkCleared(input string tag);
    #1;
    check(hostOut  == '0, tag, hostOut,  '0);
    check(bank1Out == '0, tag, bank1Out, '0);
    check(bank2Out == '0, tag, bank2Out, '0);
  endtask

  initial begin
    rstN = 1'b0;
    applyRow('{12'hFFF, 1'b1, 12'hFFF, 1'b1, 12'hFFF, 1'b1, 4'b0000, 1'b1, 3'b111});
    clearModel();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: latches closed during reset show cleared storage
    checkCleared("R1 reset state");
    check(hostOutEn == '0, "R6 reset enable", hostOutEn, '0);
    applyRow('0);
    oeV = 3'b111;
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NROW; i++) begin
      applyRow(TBL[i]);
      checkAndStep();
    end

    // R8: undriven host input ignored, bus-hold value feeds an open latch
    applyRow('{12'h5F0, 1'b1, 12'h000, 1'b0, 12'h000, 1'b0, 4'b0000, 1'b0, 3'b001});
    checkAndStep();
    applyRow('{12'h0AF, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 4'b0011, 1'b0, 3'b001});
    checkAndStep();
    check(bank1Out == 12'h5F0, "R8 held host level", bank1Out, 12'h5F0);

    // R9 / R7: open only bank 2, bank 1 keeps its value
    applyRow('{12'h9E1, 1'b1, 12'h000, 1'b0, 12'h000, 1'b0, 4'b0010, 1'b0, 3'b001});
    checkAndStep();
    applyRow('{12'h111, 1'b1, 12'h000, 1'b0, 12'h000, 1'b0, 4'b0000, 1'b0, 3'b001});
    #1;
    check(bank2Out == 12'h9E1, "R7 bank2 only", bank2Out, 12'h9E1);
    check(bank1Out == 12'h5F0, "R9 bank1 untouched", bank1Out, 12'h5F0);
    @(negedge clk);

    // contention case: flagged and not data-checked
    applyRow('{12'h222, 1'b1, 12'h000, 1'b0, 12'h000, 1'b0, 4'b0000, 1'b0, 3'b000});
    checkAndStep();

    // R1: asynchronous clear mid-run, observed before any clock edge
    applyRow('0);
    oeV = 3'b111;
    #1;
    rstN = 1'b0;
    checkCleared("R1 async clear");
    clearModel();
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAndStep();

    $display("contention cases flagged: %0d", contentions);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #20000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule